// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad of 4096 words of 32 bits, split into 16 independent banks. It takes one group of 16 lane requests at a time. Each lane has its own valid bit, write flag, 12-bit word address and 32-bit write data. The block sorts the lanes by bank and serves the whole group in as few passes as the bank collisions allow. It then returns read data for every lane with a one-cycle done pulse, and it reports how many passes the group needed.

The low four address bits select the bank and the upper eight bits select the row inside that bank. A bank can serve one distinct address in each two-cycle pass. Lanes that name the same address share that access, so a group whose lanes all read one word completes as fast as a group spread over all banks. Lanes that hit one bank at different addresses are serialized over extra passes. The pass count equals the largest number of distinct addresses that land in any single bank.

Top module: `banked_scratchpad`

## Requirements
- R1: After reset, `grp_ready` is 1, `grp_done` is 0, `grp_passes` is 0 and every lane of `lane_rdata` is 0.
- R2: A word address selects bank `addr[3:0]` and row `addr[11:4]`. A word written by a group is returned unchanged to a lane that reads the same address in a later group.
- R3: A group whose active lanes all fall in different banks takes one pass. `grp_done` is high in the cycle after the second rising edge that follows the accepting edge.
- R4: A group whose active lanes all name one address takes one pass, and every reading lane receives that word.
- R5: When k distinct addresses fall in one bank, the group takes k passes. `grp_done` is high in the cycle after the 2k-th rising edge that follows the accepting edge.
- R6: In each pass, lanes with the same address share one access even while other lanes of the same bank wait for a later pass. The pass count is therefore the number of distinct addresses per bank, not the number of lanes.
- R7: When several lanes of one group write the same address, the data of the highest-numbered of those lanes is stored.
- R8: A lane that reads an address written by another lane of the same group receives the value held before the group.
- R9: Inactive lanes (valid bit 0) write nothing and add nothing to the pass count. Their `lane_rdata` is 0, as is the `lane_rdata` of writing lanes. A group with no active lane takes one pass.
- R10: `grp_ready` is low from the accepting edge until `grp_done`. `grp_valid` has no effect while `grp_ready` is low. `grp_done` lasts exactly one cycle.
- R11: `grp_passes` is loaded at acceptance with the maximum, over all banks, of the number of distinct active addresses in that bank, with a minimum of 1. It holds that value until the next group is accepted. `lane_rdata` holds until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_valid | input | 1 | Offers a request group; taken on an edge where `grp_ready` is 1 |
| lane_vld | input | 16 | Per-lane active bit |
| lane_wr | input | 16 | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | 192 | Per-lane 12-bit word address, lane i at bits [12i+11:12i] |
| lane_wdata | input | 512 | Per-lane write data, lane i at bits [32i+31:32i] |
| grp_ready | output | 1 | Idle and able to take a group |
| grp_done | output | 1 | One-cycle pulse: group finished, read data valid |
| lane_rdata | output | 512 | Per-lane read data, lane i at bits [32i+31:32i] |
| grp_passes | output | 5 | Number of passes the current or last group needs |

## Verification
Two functions can fall in the same pass: a shared access, where several lanes use one address of a bank, and conflict serialization, where other lanes of that same bank wait for later passes. One directed group places eight lanes on a single address of bank 3, three more bank-3 addresses on other lanes, and lanes in other banks beside them. A second pair of groups mixes reads and multiple writes of one address within a pass. The bench's behavioural model counts distinct addresses per bank with queues and checks the pass count, the done cycle and every lane's data. Random groups over a 64-word window then provoke the same overlaps at random.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {SP_IDLE, SP_SERVE, SP_GAP} sp_state_e;
endpackage

// File: rtl/sp_bank_ram.sv
module sp_bank_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  // read returns the word held before a same-edge write
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wd;
      q <= mem[idx];
    end
  end
endmodule

// File: rtl/sp_bank_pick.sv
module sp_bank_pick #(
  parameter int LANES   = 16,
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int BB      = 4,
  parameter int BANK_ID = 0,
  localparam int IW     = AW - BB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    pending,
  input  logic [LANES-1:0]    wr,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*DW-1:0] wdata,
  output logic [LANES-1:0]    grant,
  output logic                en,
  output logic                we,
  output logic [IW-1:0]       idx,
  output logic [DW-1:0]       wd
);
  logic [AW-1:0] lead;

  function automatic logic in_bank(input logic [AW-1:0] a);
    return a[BB-1:0] == BB'(BANK_ID);
  endfunction

  // leader: lowest-numbered pending lane of this bank
  always_comb begin
    en   = 1'b0;
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i] && in_bank(addr[i*AW +: AW])) begin
        en   = 1'b1;
        lead = addr[i*AW +: AW];
      end
    end
  end

  // every pending lane with the leader's address rides along;
  // the highest-numbered writer among them supplies the data
  always_comb begin
    we = 1'b0;
    wd = '0;
    for (int i = 0; i < LANES; i++) begin
      grant[i] = en && pending[i] && (addr[i*AW +: AW] == lead);
      if (grant[i] && wr[i]) begin
        we = 1'b1;
        wd = wdata[i*DW +: DW];
      end
    end
  end

  assign idx = lead[AW-1:BB];

  // R7: a write strobe only comes from a granted writing lane
  a_r7_write_from_grant: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ((grant & wr) != '0));
  // R6: a grant never reaches a lane that is no longer pending
  a_r6_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pending) == '0);
endmodule

// File: rtl/sp_pass_count.sv
module sp_pass_count #(
  parameter int LANES = 16,
  parameter int AW    = 12,
  parameter int BB    = 4,
  parameter int CW    = 5,
  localparam int NB   = 1 << BB
) (
  input  logic [LANES-1:0]    vld,
  input  logic [LANES*AW-1:0] addr,
  output logic [CW-1:0]       passes
);
  function automatic logic [CW-1:0] worst_bank(input logic [LANES-1:0] v,
                                               input logic [LANES*AW-1:0] a);
    int per_bank [NB];
    int best;
    logic fresh;
    for (int b = 0; b < NB; b++) per_bank[b] = 0;
    best = 1;
    for (int i = 0; i < LANES; i++) begin
      fresh = v[i];
      for (int j = 0; j < i; j++)
        if (v[j] && a[j*AW +: AW] == a[i*AW +: AW]) fresh = 1'b0;
      if (fresh) begin
        per_bank[a[i*AW +: BB]]++;
        if (per_bank[a[i*AW +: BB]] > best) best = per_bank[a[i*AW +: BB]];
      end
    end
    return CW'(best);
  endfunction

  assign passes = worst_bank(vld, addr);
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int WORDS  = 4096,
  parameter int DW     = 32,
  localparam int AW    = $clog2(WORDS),
  localparam int BB    = $clog2(BANKS),
  localparam int DEPTH = WORDS / BANKS,
  localparam int IW    = AW - BB,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grp_valid,
  input  logic [LANES-1:0]    lane_vld,
  input  logic [LANES-1:0]    lane_wr,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*DW-1:0] lane_wdata,
  output logic                grp_ready,
  output logic                grp_done,
  output logic [LANES*DW-1:0] lane_rdata,
  output logic [CW-1:0]       grp_passes
);
  import sp_pkg::*;

  sp_state_e           state;
  logic [LANES-1:0]    wr_q, pend_q, served_q, grant_all;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q, rd_q;
  logic                done_q;
  logic [CW-1:0]       passes_q, passes_w;
  logic                fire, accept;

  logic [LANES-1:0] bgrant [BANKS];
  logic             ben    [BANKS];
  logic             bwe    [BANKS];
  logic [IW-1:0]    bidx   [BANKS];
  logic [DW-1:0]    bwd    [BANKS];
  logic [DW-1:0]    bank_q [BANKS];

  assign fire      = (state == SP_SERVE);
  assign accept    = (state == SP_IDLE) && grp_valid;
  assign grp_ready = (state == SP_IDLE);
  assign grp_done  = done_q;
  assign lane_rdata = rd_q;
  assign grp_passes = passes_q;

  sp_pass_count #(.LANES(LANES), .AW(AW), .BB(BB), .CW(CW)) u_cnt (
    .vld(lane_vld), .addr(lane_addr), .passes(passes_w));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sp_bank_pick #(.LANES(LANES), .AW(AW), .DW(DW), .BB(BB), .BANK_ID(b)) u_pick (
      .clk(clk), .rst_n(rst_n), .pending(pend_q), .wr(wr_q), .addr(addr_q),
      .wdata(wdata_q), .grant(bgrant[b]), .en(ben[b]), .we(bwe[b]),
      .idx(bidx[b]), .wd(bwd[b]));
    sp_bank_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk(clk), .en(ben[b] && fire), .we(bwe[b] && fire), .idx(bidx[b]),
      .wd(bwd[b]), .q(bank_q[b]));
  end

  always_comb begin
    grant_all = '0;
    for (int b = 0; b < BANKS; b++) grant_all = grant_all | bgrant[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SP_IDLE;
      wr_q     <= '0;
      pend_q   <= '0;
      served_q <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_q     <= '0;
      done_q   <= 1'b0;
      passes_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        SP_IDLE: if (grp_valid) begin
          wr_q     <= lane_wr;
          addr_q   <= lane_addr;
          wdata_q  <= lane_wdata;
          pend_q   <= lane_vld;
          passes_q <= passes_w;
          rd_q     <= '0;
          state    <= SP_SERVE;
        end
        SP_SERVE: begin
          served_q <= grant_all;
          pend_q   <= pend_q & ~grant_all;
          state    <= SP_GAP;
        end
        default: begin
          for (int i = 0; i < LANES; i++)
            if (served_q[i] && !wr_q[i])
              rd_q[i*DW +: DW] <= bank_q[addr_q[i*AW +: BB]];
          if (pend_q == '0) begin
            state  <= SP_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= SP_SERVE;
          end
        end
      endcase
    end
  end

  // ---------------- checker logic ----------------
  logic [CW-1:0] chk_passes;
  int            grant_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_passes <= '0;
    else if (accept) chk_passes <= '0;
    else if (fire)   chk_passes <= chk_passes + 1'b1;
  end

  always_comb begin
    grant_sum = 0;
    for (int b = 0; b < BANKS; b++) grant_sum += $countones(bgrant[b]);
  end

  // R11: passes actually run equal the count announced at acceptance
  a_r11_pass_count: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> (chk_passes == passes_q));
  // R11: announced count never exceeds the lane count
  a_r11_bound: assert property (@(posedge clk) disable iff (!rst_n)
    passes_q <= CW'(LANES));
  // R10: done is a single-cycle pulse and coincides with ready
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done);
  a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> grp_ready);
  // R5: every pass with pending lanes serves at least one of them
  a_r5_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pend_q != '0) |-> (grant_all != '0));
  // R6: a lane is granted by at most one bank per pass
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (grant_sum == $countones(grant_all)));
endmodule

// File: tb/sim_banked_scratchpad.sv
module sim_banked_scratchpad;
  localparam int CLK_NS = 10;
  localparam int L = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           grp_valid = 1'b0;
  logic [L-1:0]   lane_vld = '0, lane_wr = '0;
  logic [L*12-1:0] lane_addr = '0;
  logic [L*32-1:0] lane_wdata = '0;
  logic           grp_ready, grp_done;
  logic [L*32-1:0] lane_rdata;
  logic [4:0]     grp_passes;

  banked_scratchpad u0 (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .lane_vld(lane_vld),
    .lane_wr(lane_wr), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
    .grp_ready(grp_ready), .grp_done(grp_done), .lane_rdata(lane_rdata),
    .grp_passes(grp_passes));

  always #(CLK_NS/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // behavioural reference model
  int          m_left = 0;
  bit          m_done = 0;
  int          m_passes = 0;
  logic [31:0] m_rd [L];
  logic [31:0] mem_m [int];
  logic [11:0] s_addr [L];
  logic [31:0] s_data [L];

  initial for (int i = 0; i < L; i++) m_rd[i] = '0;

  function automatic void check(logic [31:0] act, logic [31:0] exp, string req, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endfunction

  task automatic model_accept();
    int q [16][$];
    int a, best;
    bit seen;
    best = 1;
    for (int i = 0; i < L; i++) begin
      if (!lane_vld[i]) continue;
      a = int'(lane_addr[i*12 +: 12]);
      seen = 0;
      foreach (q[a % 16][k]) if (q[a % 16][k] == a) seen = 1;
      if (!seen) q[a % 16].push_back(a);
      if (q[a % 16].size() > best) best = q[a % 16].size();
    end
    for (int i = 0; i < L; i++) begin
      a = int'(lane_addr[i*12 +: 12]);
      m_rd[i] = (lane_vld[i] && !lane_wr[i]) ? (mem_m.exists(a) ? mem_m[a] : 32'hx) : 32'h0;
    end
    for (int i = 0; i < L; i++)
      if (lane_vld[i] && lane_wr[i]) mem_m[int'(lane_addr[i*12 +: 12])] = lane_wdata[i*32 +: 32];
    m_passes = best;
    m_left = 2 * best;
  endtask

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) m_left = 0;
    else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_done = 1;
    end else if (grp_valid) model_accept();
  end

  always @(negedge clk) if (rst_n) begin
    check(32'(grp_ready), 32'(m_left == 0), cur_req, "ready");
    check(32'(grp_done), 32'(m_done), cur_req, "done");
    check(32'(grp_passes), 32'(m_passes), cur_req, "passes");
    if (m_left == 0)
      for (int i = 0; i < L; i++)
        check(lane_rdata[i*32 +: 32], m_rd[i], cur_req, $sformatf("rdata lane %0d", i));
  end

  task automatic run_group(input logic [L-1:0] v, input logic [L-1:0] w, input bit hold_busy);
    @(negedge clk);
    lane_vld = v;
    lane_wr = w;
    for (int i = 0; i < L; i++) begin
      lane_addr[i*12 +: 12] = s_addr[i];
      lane_wdata[i*32 +: 32] = s_data[i];
    end
    grp_valid = 1'b1;
    @(negedge clk);
    if (hold_busy) begin
      // R10: a different group is offered throughout the busy window
      lane_vld = '1;
      lane_wr = '1;
      for (int i = 0; i < L; i++) begin
        lane_addr[i*12 +: 12] = 12'h022;
        lane_wdata[i*32 +: 32] = 32'hDEAD_0000 + i;
      end
      while (m_left != 0) @(negedge clk);
    end
    grp_valid = 1'b0;
    while (m_left != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check(32'(grp_ready), 32'd1, "R1", "ready in reset");
    check(32'(grp_done), 32'd0, "R1", "done in reset");
    check(32'(grp_passes), 32'd0, "R1", "passes in reset");
    check(lane_rdata[31:0], 32'd0, "R1", "rdata lane 0 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: one lane per bank (address 17*i -> bank i, row i), all writes
    cur_req = "R3";
    for (int i = 0; i < L; i++) begin s_addr[i] = 12'(17 * i); s_data[i] = 32'hA000 + i; end
    run_group('1, '1, 0);
    // R2: read them back
    cur_req = "R2";
    run_group('1, '0, 0);
    // R4: broadcast of one word to all lanes
    cur_req = "R4";
    for (int i = 0; i < L; i++) s_addr[i] = 12'h055;
    run_group('1, '0, 0);
    // R5: sixteen rows of bank 3
    cur_req = "R5";
    for (int i = 0; i < L; i++) begin s_addr[i] = 12'(16 * i + 3); s_data[i] = 32'hB300 + i; end
    run_group('1, '1, 0);
    for (int i = 0; i < L; i++) s_addr[i] = 12'(16 * (15 - i) + 3);
    run_group('1, '0, 0);
    // R6: shared address in bank 3 next to bank-3 conflicts and other banks
    cur_req = "R6";
    for (int i = 0; i < 8; i++) s_addr[i] = 12'h003;
    s_addr[8] = 12'h013; s_addr[9] = 12'h023; s_addr[10] = 12'h3F0; s_addr[11] = 12'h3F1;
    s_addr[12] = 12'h011; s_addr[13] = 12'h022; s_addr[14] = 12'h033; s_addr[15] = 12'h044;
    run_group(16'hF3FF, '0, 0);
    // R8: read of a word written by other lanes of the same group
    cur_req = "R8";
    for (int i = 0; i < L; i++) begin s_addr[i] = 12'h003; s_data[i] = 32'h7770_0000 + i; end
    run_group(16'h1094, 16'h1084, 0);
    // R7: highest writing lane (12) won
    cur_req = "R7";
    run_group(16'h0001, 16'h0000, 0);
    // R9: inactive writers change nothing; inactive lanes return zero
    cur_req = "R9";
    for (int i = 0; i < L; i++) begin s_addr[i] = 12'h011; s_data[i] = 32'hBAD0_0000 + i; end
    run_group('0, '1, 0);
    run_group(16'h0020, '0, 0);
    // R10: group offered while busy is ignored, then 0x022 read back
    cur_req = "R10";
    for (int i = 0; i < L; i++) s_addr[i] = 12'(16 * (i % 4) + 3);
    run_group(16'h000F, '0, 1);
    for (int i = 0; i < L; i++) s_addr[i] = 12'h022;
    run_group(16'hFFFF, '0, 0);
    // R11: fill a 64-word window, then random mixed groups
    cur_req = "R11";
    for (int g = 0; g < 4; g++) begin
      for (int i = 0; i < L; i++) begin s_addr[i] = 12'(16 * g + i); s_data[i] = $urandom; end
      run_group('1, '1, 0);
    end
    for (int g = 0; g < 40; g++) begin
      for (int i = 0; i < L; i++) begin s_addr[i] = 12'($urandom % 64); s_data[i] = $urandom; end
      run_group(16'($urandom), 16'($urandom), 0);
    end
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule